// File: doc/BRIEF.md
# Error-Correcting Word Memory with Check-Bit Fault Injection

This block is a small word memory in which every 32-bit word carries seven check bits of an extended Hamming code. A read corrects any single flipped bit, whether it sits in the data or in the check bits. A read with two flipped bits is flagged as uncorrectable. All traffic uses one simple bus made of a request, a write enable, a byte address, write data, read data and a ready pulse. Every access is a full word.

Fault injection for self-test works in two ways. Check-bit generation can be switched off, so that a data write lands without its code. In a diagnostic mode, each word's check bits also appear in a second address window. There they can be read, altered and written back.

Each error class has a sticky flag and a register that holds the address of the first word hit by that kind of error. Software clears a flag, together with its address register, by writing a one to the flag's bit.

Top module: `secded_ram`

## Requirements
- R1: Each cycle with `req` high produces a `ready` pulse exactly one cycle later, and read data is valid on `rdata` during that pulse. `ready` stays low in a cycle that follows a cycle without a request.
- R2: While generation is on (control bit 0 at 0x800), a write to the data window (0x000 + 4·index, index below the depth) stores the word and its check bits. A later read returns the word and raises no flag.
- R3: Check-bit layout: data bit k occupies the k-th position, counting from 1, that is not a power of two. Check bit i (i = 0..5) is the parity of the data bits whose position has bit i set. Bit 6 makes the 39 stored bits even. Thus data 0 gives check 0x00 and data 1 gives check 0x43.
- R4: While generation is off, a data-window write changes only the data bits. The stored check bits stay as they were.
- R5: While diagnostics are on (control bit 1), address 0x400 + 4·index reads that word's check bits zero-extended, and a write there replaces them with write-data bits 6:0. While diagnostics are off, that window reads 0 and ignores writes.
- R6: A data read with one flipped bit returns the corrected word and sets the single-error flag (status bit 0 at 0x804, port `sbeFlag`).
- R7: A data read with two flipped bits sets the uncorrectable flag (status bit 1, port `ueFlag`) and does not set the single-error flag.
- R8: The byte address of the word that set a flag is captured: single errors at 0x808, uncorrectable errors at 0x80C. Further errors of the same kind do not change it while the flag is set.
- R9: Writing 1 to a status bit clears that flag and its address register to 0. A 0 bit leaves the other flag and its address untouched.
- R10: After reset the control register reads 0x1 (generation on, diagnostics off), and status and both address registers read 0.
- R11: Error checking runs on every data read whether generation is on or off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low reset, synchronous |
| req | input | 1 | Access request for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address; low two bits must be zero |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while `ready` is high |
| ready | output | 1 | Completion pulse, one cycle after `req` |
| sbeFlag | output | 1 | Sticky single-error flag |
| ueFlag | output | 1 | Sticky uncorrectable-error flag |

## Verification
An access taken at a rising edge completes at the next edge. `ready` and the corrected word are therefore sampled at the falling edge that follows, which is also where the bench drops `req`. The flags and address registers load at the edge that ends the data-return cycle. Because the bench starts its next access on the following falling edge, a status or address read issued back-to-back already sees the new values. The bench also checks that `ready` is low at the start of each access.

// File: rtl/secded_ram_pkg.sv
package secded_ram_pkg;
  localparam int DATA_W = 32;
  localparam int HAM_W  = 6;
  localparam int CHK_W  = HAM_W + 1;
  localparam int CODE_W = DATA_W + HAM_W;  // Hamming positions 1..38
  localparam int ADDR_W = 12;

  typedef struct packed {
    logic rd;
    logic wrData;
    logic wrChk;
    logic genChk;
  } memStrobe_t;

  typedef enum logic [1:0] {SEL_NONE, SEL_DATA, SEL_CHK, SEL_REG} rdSel_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              sbe;
    logic              dbe;
  } decode_t;

  function automatic logic isPow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [HAM_W-1:0] hamBits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    int k;
    h = '0;
    k = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!isPow2(p)) begin
        if (d[k[4:0]]) h ^= p[HAM_W-1:0];
        k++;
      end
    end
    return h;
  endfunction

  function automatic logic [CHK_W-1:0] eccEncode(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = hamBits(d);
    return {(^d) ^ (^h), h};
  endfunction

  function automatic decode_t eccDecode(input logic [DATA_W-1:0] d,
                                        input logic [CHK_W-1:0] c);
    logic [HAM_W-1:0] s;
    logic par;
    int k;
    decode_t r;
    s = hamBits(d) ^ c[HAM_W-1:0];
    par = (^d) ^ (^c);
    r.data = d;
    r.sbe = 1'b0;
    r.dbe = 1'b0;
    if (par) begin
      if (int'(s) > CODE_W) begin
        r.dbe = 1'b1;
      end else begin
        r.sbe = 1'b1;
        k = 0;
        for (int p = 1; p <= CODE_W; p++) begin
          if (!isPow2(p)) begin
            if (p == int'(s)) r.data[k[4:0]] = ~d[k[4:0]];
            k++;
          end
        end
      end
    end else if (s != '0) begin
      r.dbe = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/secded_ram_ctrl.sv
module secded_ram_ctrl
  import secded_ram_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready,
  output logic              sbeFlag,
  output logic              ueFlag,
  output memStrobe_t        strobe,
  output logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] corrData,
  input  logic [CHK_W-1:0]  storedChk,
  input  logic              errSbe,
  input  logic              errDbe
);
  localparam logic [1:0] WIN_DATA = 2'd0;
  localparam logic [1:0] WIN_CHK  = 2'd1;
  localparam logic [1:0] WIN_REG  = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_SADR = 2'd2;
  localparam logic [1:0] REG_UADR = 2'd3;

  logic              eccOn, diagOn;
  logic [ADDR_W-1:0] sbeAddr, ueAddr;
  logic [IDX_W-1:0]  rdIdx;
  logic [DATA_W-1:0] regVal, regRd;
  rdSel_e            sel, selNext;
  logic              hitData, hitChk, hitReg, aligned, inRange;
  logic [1:0]        win;
  logic [7:0]        wordOff;
  logic              newSbe, newDbe, clrSbe, clrDbe, ctrlWr;
  logic [ADDR_W-1:0] errAddr;

  assign win     = addr[11:10];
  assign wordOff = addr[9:2];
  assign aligned = addr[1:0] == 2'b00;
  assign inRange = int'(wordOff) < DEPTH;
  assign idx     = wordOff[IDX_W-1:0];
  assign hitData = aligned && win == WIN_DATA && inRange;
  assign hitChk  = aligned && win == WIN_CHK && inRange && diagOn;
  assign hitReg  = aligned && win == WIN_REG && addr[9:4] == '0;

  always_comb begin
    strobe.rd     = req && !we && (hitData || hitChk);
    strobe.wrData = req && we && hitData;
    strobe.wrChk  = req && we && (hitChk || (hitData && eccOn));
    strobe.genChk = hitData;
  end

  always_comb begin
    unique case (addr[3:2])
      REG_CTRL: regVal = {{(DATA_W-2){1'b0}}, diagOn, eccOn};
      REG_STAT: regVal = {{(DATA_W-2){1'b0}}, ueFlag, sbeFlag};
      REG_SADR: regVal = {{(DATA_W-ADDR_W){1'b0}}, sbeAddr};
      default:  regVal = {{(DATA_W-ADDR_W){1'b0}}, ueAddr};
    endcase
  end

  assign selNext = (!req || we) ? SEL_NONE :
                   hitData ? SEL_DATA :
                   hitChk  ? SEL_CHK  :
                   hitReg  ? SEL_REG  : SEL_NONE;

  assign ctrlWr  = req && we && hitReg && addr[3:2] == REG_CTRL;
  assign clrSbe  = req && we && hitReg && addr[3:2] == REG_STAT && wdata[0];
  assign clrDbe  = req && we && hitReg && addr[3:2] == REG_STAT && wdata[1];
  assign newSbe  = ready && sel == SEL_DATA && errSbe;
  assign newDbe  = ready && sel == SEL_DATA && errDbe;
  assign errAddr = {{(ADDR_W-IDX_W-2){1'b0}}, rdIdx, 2'b00};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ready   <= 1'b0;
      sel     <= SEL_NONE;
      regRd   <= '0;
      rdIdx   <= '0;
      eccOn   <= 1'b1;
      diagOn  <= 1'b0;
      sbeFlag <= 1'b0;
      ueFlag  <= 1'b0;
      sbeAddr <= '0;
      ueAddr  <= '0;
    end else begin
      ready <= req;
      sel   <= selNext;
      regRd <= regVal;
      rdIdx <= idx;
      if (ctrlWr) begin
        eccOn  <= wdata[0];
        diagOn <= wdata[1];
      end
      if (newSbe) begin
        sbeFlag <= 1'b1;
        if (!sbeFlag || clrSbe) sbeAddr <= errAddr;
      end else if (clrSbe) begin
        sbeFlag <= 1'b0;
        sbeAddr <= '0;
      end
      if (newDbe) begin
        ueFlag <= 1'b1;
        if (!ueFlag || clrDbe) ueAddr <= errAddr;
      end else if (clrDbe) begin
        ueFlag <= 1'b0;
        ueAddr <= '0;
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: rdata = corrData;
      SEL_CHK:  rdata = {{(DATA_W-CHK_W){1'b0}}, storedChk};
      SEL_REG:  rdata = regRd;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/secded_ram_dp.sv
module secded_ram_dp
  import secded_ram_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  memStrobe_t        strobe,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] corrData,
  output logic [CHK_W-1:0]  storedChk,
  output logic              errSbe,
  output logic              errDbe
);
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [CHK_W-1:0]  chkMem  [DEPTH];
  logic [DATA_W-1:0] rawData;
  logic [CHK_W-1:0]  rawChk;
  decode_t           dec;

  always_ff @(posedge clk) begin
    if (strobe.wrData) dataMem[idx] <= wdata;
    if (strobe.wrChk)
      chkMem[idx] <= strobe.genChk ? eccEncode(wdata) : wdata[CHK_W-1:0];
    if (strobe.rd) begin
      rawData <= dataMem[idx];
      rawChk  <= chkMem[idx];
    end
  end

  assign dec       = eccDecode(rawData, rawChk);
  assign corrData  = dec.data;
  assign storedChk = rawChk;
  assign errSbe    = dec.sbe;
  assign errDbe    = dec.dbe;
endmodule

// File: rtl/secded_ram.sv
module secded_ram
  import secded_ram_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready,
  output logic              sbeFlag,
  output logic              ueFlag
);
  localparam int IDX_W = $clog2(DEPTH);

  memStrobe_t        strobe;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] corrData;
  logic [CHK_W-1:0]  storedChk;
  logic              errSbe, errDbe;

  secded_ram_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ready(ready), .sbeFlag(sbeFlag), .ueFlag(ueFlag),
    .strobe(strobe), .idx(idx), .corrData(corrData), .storedChk(storedChk),
    .errSbe(errSbe), .errDbe(errDbe)
  );

  secded_ram_dp #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .strobe(strobe), .idx(idx), .wdata(wdata),
    .corrData(corrData), .storedChk(storedChk), .errSbe(errSbe), .errDbe(errDbe)
  );
endmodule

// File: rtl/secded_ram_chk.sv
module secded_ram_chk (
  input logic        clk,
  input logic        rstN,
  input logic        req,
  input logic        we,
  input logic [11:0] addr,
  input logic [31:0] wdata,
  input logic        ready,
  input logic        sbeFlag,
  input logic        ueFlag
);
  logic statWr;
  assign statWr = req && we && addr == 12'h804;

  a_r1_ready_follows: assert property (@(posedge clk) disable iff (!rstN)
    req |=> ready);
  a_r1_no_stray_ready: assert property (@(posedge clk) disable iff (!rstN)
    !req |=> !ready);
  a_r6_sbe_after_return: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sbeFlag) |-> $past(ready));
  a_r7_ue_after_return: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ueFlag) |-> $past(ready));
  a_r8_sbe_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (sbeFlag && !(statWr && wdata[0])) |=> sbeFlag);
  a_r8_ue_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ueFlag && !(statWr && wdata[1])) |=> ueFlag);
  a_r9_sbe_clear: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && wdata[0] && !ready) |=> !sbeFlag);
  a_r9_ue_clear: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && wdata[1] && !ready) |=> !ueFlag);
endmodule

bind secded_ram secded_ram_chk i_chk (
  .clk(clk), .rstN(rstN), .req(req), .we(we), .addr(addr), .wdata(wdata),
  .ready(ready), .sbeFlag(sbeFlag), .ueFlag(ueFlag)
);

// File: tb/test_secded_ram.sv
`timescale 1ns/1ps
module test_secded_ram;
  localparam logic [11:0] A_CTRL = 12'h800;
  localparam logic [11:0] A_STAT = 12'h804;
  localparam logic [11:0] A_SADR = 12'h808;
  localparam logic [11:0] A_UADR = 12'h80C;
  localparam logic [11:0] CHK    = 12'h400;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready, sbeFlag, ueFlag;
  int nCmp = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  secded_ram i_secded_ram (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ready(ready), .sbeFlag(sbeFlag), .ueFlag(ueFlag)
  );

  task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busOp(input logic isWr, input logic [11:0] a, input logic [31:0] d,
                       output logic [31:0] q);
    @(negedge clk);
    expect32("R1 ready idle", {31'b0, ready}, 32'd0);
    req = 1'b1; we = isWr; addr = a; wdata = d;
    @(negedge clk);
    expect32("R1 ready pulse", {31'b0, ready}, 32'd1);
    q = rdata;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] q;
    busOp(1'b1, a, d, q);
  endtask

  task automatic rdChk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] q;
    busOp(1'b0, a, 32'h0, q);
    expect32(tag, q, exp);
  endtask

  task automatic rdVal(input logic [11:0] a, output logic [31:0] q);
    busOp(1'b0, a, 32'h0, q);
  endtask

  task automatic tReset();
    expect32("R10 sbeFlag port", {31'b0, sbeFlag}, 32'd0);
    expect32("R10 ueFlag port", {31'b0, ueFlag}, 32'd0);
    rdChk("R10 control", A_CTRL, 32'h1);
    rdChk("R10 status", A_STAT, 32'h0);
    rdChk("R10 sbe addr", A_SADR, 32'h0);
    rdChk("R10 ue addr", A_UADR, 32'h0);
  endtask

  task automatic tEncode();
    wr(A_CTRL, 32'h3);
    wr(12'h014, 32'h0);
    wr(12'h018, 32'h1);
    wr(12'h01C, 32'hDEADBEEF);
    rdChk("R3 check of zero", CHK + 12'h014, 32'h0);
    rdChk("R3 check of one", CHK + 12'h018, 32'h43);
    rdChk("R5 control diag on", A_CTRL, 32'h3);
    rdChk("R2 data readback", 12'h01C, 32'hDEADBEEF);
    rdChk("R2 no flags", A_STAT, 32'h0);
  endtask

  task automatic tDiagOff();
    wr(A_CTRL, 32'h1);
    rdChk("R5 window reads 0 when off", CHK + 12'h018, 32'h0);
    wr(CHK + 12'h018, 32'h7F);
    wr(A_CTRL, 32'h3);
    rdChk("R5 write ignored when off", CHK + 12'h018, 32'h43);
    rdChk("R5 data intact", 12'h018, 32'h1);
    rdChk("R5 no flags", A_STAT, 32'h0);
  endtask

  task automatic tCheckFault();
    logic [31:0] c;
    logic [31:0] q;
    wr(12'h028, 32'hA5A51234);
    rdVal(CHK + 12'h028, c);
    wr(CHK + 12'h028, c ^ 32'h4);
    rdChk("R6 corrected after check flip", 12'h028, 32'hA5A51234);
    rdChk("R6 single flag", A_STAT, 32'h1);
    expect32("R6 sbeFlag port", {31'b0, sbeFlag}, 32'd1);
    rdChk("R8 sbe addr", A_SADR, 32'h028);
    rdChk("R8 ue addr untouched", A_UADR, 32'h0);
    wr(CHK + 12'h028, c ^ 32'h44);
    rdVal(12'h028, q);
    rdChk("R7 ue flag set", A_STAT, 32'h3);
    rdChk("R8 ue addr", A_UADR, 32'h028);
    wr(A_STAT, 32'h3);
    rdChk("R9 status cleared", A_STAT, 32'h0);
    rdChk("R9 sbe addr cleared", A_SADR, 32'h0);
    rdChk("R9 ue addr cleared", A_UADR, 32'h0);
  endtask

  task automatic tDataFault();
    logic [31:0] c0;
    logic [31:0] q;
    wr(A_CTRL, 32'h3);
    wr(12'h050, 32'h12345678);
    rdVal(CHK + 12'h050, c0);
    wr(A_CTRL, 32'h2);
    wr(12'h050, 32'h12345678 ^ 32'h0002_0000);
    rdChk("R4 check unchanged", CHK + 12'h050, c0);
    rdChk("R11 corrected with generation off", 12'h050, 32'h12345678);
    rdChk("R6 data flip flag", A_STAT, 32'h1);
    rdChk("R8 sbe addr data flip", A_SADR, 32'h050);
    wr(A_CTRL, 32'h3);
    wr(12'h054, 32'h55);
    wr(A_CTRL, 32'h2);
    wr(12'h054, 32'h54);
    rdChk("R6 second word corrected", 12'h054, 32'h55);
    rdChk("R8 sbe addr holds first", A_SADR, 32'h050);
    wr(12'h050, 32'h12345678 ^ 32'h4000_0008);
    rdVal(12'h050, q);
    rdChk("R7 both flags", A_STAT, 32'h3);
    expect32("R7 ueFlag port", {31'b0, ueFlag}, 32'd1);
    rdChk("R8 ue addr data flip", A_UADR, 32'h050);
    wr(A_STAT, 32'h1);
    rdChk("R9 only sbe cleared", A_STAT, 32'h2);
    rdChk("R9 sbe addr zero", A_SADR, 32'h0);
    rdChk("R9 ue addr kept", A_UADR, 32'h050);
    wr(A_STAT, 32'h2);
    rdChk("R9 ue cleared", A_STAT, 32'h0);
    wr(A_CTRL, 32'h1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tEncode();
    tDiagOff();
    tCheckFault();
    tDataFault();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule